// File: doc/BRIEF.md
# Two-Port Same-Address Collision Arbiter

This block sits between two independent access ports (left and right) and a small shared word array. Each port presents an enable, an address, a write strobe and write data. When both ports are enabled on the same address in the same cycle, the block chooses one winner. It pulls the loser's active-low busy flag low and blocks the loser's write inside the block, so the array is never written by the port that lost.

A mode input selects between two behaviours. As a master, the block computes busy itself and drives it out. As a slave, it ignores its own arbitration result, holds its busy outputs high, and treats a per-port busy input only as a write inhibit. Several devices can then be placed side by side to widen the data path, with a single master making the decision for all of them. Arbitration is synchronous to one clock. "Earlier" means the port whose enable and address were already present, unchanged, in the previous cycle.

Top module: `twoport_collision_arb`

## Requirements
- R1: Busy flags are active low (1 = idle, 0 = busy). In master mode, both busy outputs are 1 in any cycle where either enable is 0 or the two addresses differ.
- R2: In master mode, when both ports are enabled on the same address, the port whose enable and address were not present in the previous cycle sees busy = 0 in that same cycle, and the port that was already present keeps busy = 1.
- R3: If both ports arrive in the same cycle, the right port gets busy = 0 and the left port wins. The two busy outputs are never 0 together.
- R4: The write strobes have no influence on either busy output.
- R5: Once a port has busy = 0, it stays at 0, and the winner stays the same, for as long as the same-address collision lasts.
- R6: In master mode, a write from a port whose busy output is 0 does not change the array, while the winning port's write in that cycle does land.
- R7: In slave mode, both busy outputs are 1. A port whose busy input is 0 cannot write. A port whose busy input is 1 writes normally, even during a same-address collision.
- R8: In master mode, the busy inputs are ignored and do not block writes.
- R9: A read from the losing port is still performed. When the winner writes the same word at the same edge, the loser receives the value held before that write.
- R10: Read data is registered. It updates one clock after a cycle with enable = 1 and write strobe = 0, holds otherwise, and is 0 after reset.
- R11: If both ports write the same word at the same edge with neither write blocked, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1 = compute and drive busy, 0 = busy inputs act as write inhibit |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port registered read data |
| l_busy_i | input | 1 | Left write inhibit in slave mode, active low |
| l_busy_o | output | 1 | Left busy flag, active low |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port registered read data |
| r_busy_i | input | 1 | Right write inhibit in slave mode, active low |
| r_busy_o | output | 1 | Right busy flag, active low |

## Verification
Two things can happen at the same clock edge: the arbitration decision that blocks a write, and a read of the same word by the other port. The bench holds the winner on an address and then brings in the loser. It covers three cases: the loser writing, the loser reading while the winner writes, and both ports writing in slave mode. Each outcome is judged by reading the word back through a later clean read and by the loser's registered read data. A sweep over every address pair, arrival order and write-strobe mix checks the busy outputs within the cycle against a rule computed in the bench.

// File: rtl/twoport_arb_pkg.sv
package twoport_arb_pkg;
   localparam int NPORT = 2;
   localparam int P_L   = 0;
   localparam int P_R   = 1;

   typedef enum logic {
      SIDE_LEFT  = 1'b0,
      SIDE_RIGHT = 1'b1
   } side_e;
endpackage

// File: rtl/tp_addr_match.sv
module tp_addr_match #(
   parameter int AW = 6
) (
   input  logic          en_a,
   input  logic          en_b,
   input  logic [AW-1:0] addr_a,
   input  logic [AW-1:0] addr_b,
   output logic          hit
);
   always_comb begin
      hit = en_a & en_b & (addr_a == addr_b);
   end
endmodule

// File: rtl/tp_arbiter.sv
module tp_arbiter
   import twoport_arb_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NPORT-1:0]           en,
   input  logic [NPORT-1:0][AW-1:0]   addr,
   input  logic                       hit,
   output logic [NPORT-1:0]           busy_n
);
   logic [NPORT-1:0]          en_q;
   logic [NPORT-1:0][AW-1:0]  addr_q;
   logic [NPORT-1:0]          steady;
   logic                      coll_q;
   side_e                     win_q;
   side_e                     win_c;

   // a port is "steady" when its request was already present last cycle
   for (genvar p = 0; p < NPORT; p++) begin : g_steady
      assign steady[p] = en[p] & en_q[p] & (addr[p] == addr_q[p]);
   end

   always_comb begin
      win_c = SIDE_LEFT;
      if (hit) begin
         if (coll_q)
            win_c = win_q;
         else if (steady[P_R] && !steady[P_L])
            win_c = SIDE_RIGHT;
         else
            win_c = SIDE_LEFT;
      end
      busy_n[P_L] = !(hit && (win_c == SIDE_RIGHT));
      busy_n[P_R] = !(hit && (win_c == SIDE_LEFT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         addr_q <= '0;
         coll_q <= 1'b0;
         win_q  <= SIDE_LEFT;
      end else begin
         en_q   <= en;
         addr_q <= addr;
         coll_q <= hit;
         win_q  <= win_c;
      end
   end
endmodule

// File: rtl/tp_word_array.sv
module tp_word_array
   import twoport_arb_pkg::*;
#(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NPORT-1:0]           wr,
   input  logic [NPORT-1:0]           rd,
   input  logic [NPORT-1:0][AW-1:0]   addr,
   input  logic [NPORT-1:0][DW-1:0]   wdata,
   output logic [NPORT-1:0][DW-1:0]   rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] words [DEPTH];

   // higher index first so the left port's write is applied last
   always_ff @(posedge clk) begin
      for (int p = NPORT - 1; p >= 0; p--) begin
         if (wr[p]) words[addr[p]] <= wdata[p];
      end
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_rd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata[p] <= '0;
         else if (rd[p])
            rdata[p] <= words[addr[p]];
      end
   end
endmodule

// File: rtl/twoport_collision_arb.sv
module twoport_collision_arb
   import twoport_arb_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_mode,
   input  logic              l_en,
   input  logic              l_we,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              l_busy_i,
   output logic              l_busy_o,
   input  logic              r_en,
   input  logic              r_we,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   input  logic              r_busy_i,
   output logic              r_busy_o
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_aw
      $error("twoport_collision_arb: ADDR_W must lie in 1..12");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("twoport_collision_arb: DATA_W must be at least 1");
   end

   logic [NPORT-1:0]              en_v, we_v, bin_v, arb_n, eff_n, bout_v;
   logic [NPORT-1:0]              wr_go, rd_go;
   logic [NPORT-1:0][ADDR_W-1:0]  addr_v;
   logic [NPORT-1:0][DATA_W-1:0]  wd_v, rd_v;
   logic                          hit;

   assign en_v   = {r_en, l_en};
   assign we_v   = {r_we, l_we};
   assign bin_v  = {r_busy_i, l_busy_i};
   assign addr_v = {r_addr, l_addr};
   assign wd_v   = {r_wdata, l_wdata};

   tp_addr_match #(.AW(ADDR_W)) u_match (
      .en_a   (l_en),
      .en_b   (r_en),
      .addr_a (l_addr),
      .addr_b (r_addr),
      .hit    (hit)
   );

   tp_arbiter #(.AW(ADDR_W)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en_v),
      .addr   (addr_v),
      .hit    (hit),
      .busy_n (arb_n)
   );

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign eff_n[p]  = master_mode ? arb_n[p] : bin_v[p];
      assign bout_v[p] = master_mode ? arb_n[p] : 1'b1;
      assign wr_go[p]  = en_v[p] & we_v[p] & eff_n[p];
      assign rd_go[p]  = en_v[p] & ~we_v[p];
   end

   tp_word_array #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_go),
      .rd    (rd_go),
      .addr  (addr_v),
      .wdata (wd_v),
      .rdata (rd_v)
   );

   assign l_rdata  = rd_v[P_L];
   assign r_rdata  = rd_v[P_R];
   assign l_busy_o = bout_v[P_L];
   assign r_busy_o = bout_v[P_R];
endmodule

// File: rtl/tp_arb_chk.sv
module tp_arb_chk #(
   parameter int AW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          master_mode,
   input logic          l_en,
   input logic          r_en,
   input logic [AW-1:0] l_addr,
   input logic [AW-1:0] r_addr,
   input logic          l_busy_i,
   input logic          r_busy_i,
   input logic          l_busy_o,
   input logic          r_busy_o,
   input logic          l_wr,
   input logic          r_wr
);
   logic started;
   logic same;

   assign same = l_en && r_en && (l_addr == r_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   a_r1_idle_without_match: assert property (@(posedge clk) disable iff (!rst_n)
      !same |-> (l_busy_o && r_busy_o));

   a_r3_never_both_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !(!l_busy_o && !r_busy_o));

   a_r5_left_loss_held: assert property (@(posedge clk) disable iff (!rst_n)
      (started && master_mode && $past(master_mode) && $past(same) && same && !$past(l_busy_o))
      |-> !l_busy_o);

   a_r5_right_loss_held: assert property (@(posedge clk) disable iff (!rst_n)
      (started && master_mode && $past(master_mode) && $past(same) && same && !$past(r_busy_o))
      |-> !r_busy_o);

   a_r6_loser_cannot_write: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && (!l_busy_o || !r_busy_o)) |-> !(!l_busy_o && l_wr) && !(!r_busy_o && r_wr));

   a_r7_slave_outputs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !master_mode |-> (l_busy_o && r_busy_o));

   a_r7_slave_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
      !master_mode |-> (!(!l_busy_i && l_wr) && !(!r_busy_i && r_wr)));
endmodule

bind twoport_collision_arb tp_arb_chk #(.AW(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .master_mode (master_mode),
   .l_en        (l_en),
   .r_en        (r_en),
   .l_addr      (l_addr),
   .r_addr      (r_addr),
   .l_busy_i    (l_busy_i),
   .r_busy_i    (r_busy_i),
   .l_busy_o    (l_busy_o),
   .r_busy_o    (r_busy_o),
   .l_wr        (wr_go[0]),
   .r_wr        (wr_go[1])
);

// File: tb/twoport_collision_arb_test.sv
`timescale 1ns/1ps
module twoport_collision_arb_test;
   localparam int AW = 3;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          master_mode = 1'b1;
   logic          l_en = 0, l_we = 0, r_en = 0, r_we = 0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wdata = '0, r_wdata = '0;
   logic          l_busy_i = 1'b1, r_busy_i = 1'b1;
   logic [DW-1:0] l_rdata, r_rdata;
   logic          l_busy_o, r_busy_o;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 0;

   always #2 clk = ~clk;

   twoport_collision_arb #(.ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
      .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
      .l_rdata(l_rdata), .l_busy_i(l_busy_i), .l_busy_o(l_busy_o),
      .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
      .r_rdata(r_rdata), .r_busy_i(r_busy_i), .r_busy_o(r_busy_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_l(input logic en, input logic we, input int a, input int d);
      l_en = en; l_we = we; l_addr = AW'(a); l_wdata = DW'(d);
   endtask

   task automatic set_r(input logic en, input logic we, input int a, input int d);
      r_en = en; r_we = we; r_addr = AW'(a); r_wdata = DW'(d);
   endtask

   task automatic idle();
      set_l(0, 0, 0, 0);
      set_r(0, 0, 0, 0);
   endtask

   // drive for one cycle, then return just after the edge
   task automatic cyc();
      tick();
   endtask

   task automatic read_l(input int a, output logic [DW-1:0] v);
      idle(); set_l(1, 0, a, 0); cyc(); v = l_rdata; idle();
   endtask

   task automatic read_r(input int a, output logic [DW-1:0] v);
      idle(); set_r(1, 0, a, 0); cyc(); v = r_rdata; idle();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [DW-1:0] v;
      logic [DW-1:0] held;
      string         tag;
      bit            e_l, e_r;

      // reset state (R10, R1)
      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset l_rdata", l_rdata, 0);
      chk("R10 reset r_rdata", r_rdata, 0);
      chk("R1 reset busy pair", {l_busy_o, r_busy_o}, 2'b11);
      rst_n = 1'b1;
      tick();

      // sweep: address pairs x arrival order x write strobes (R1 R2 R3 R4)
      for (int la = 0; la < (1 << AW); la++) begin
         for (int ra = 0; ra < (1 << AW); ra++) begin
            for (int ord = 0; ord < 3; ord++) begin
               for (int wc = 0; wc < 4; wc++) begin
                  idle();
                  cyc();
                  if (ord == 0) set_l(1, 0, la, 0);
                  if (ord == 1) set_r(1, 0, ra, 0);
                  #1;
                  chk("R1 single port", {l_busy_o, r_busy_o}, 2'b11);
                  cyc();
                  set_l(1, wc[0], la, la * 16 + ra);
                  set_r(1, wc[1], ra, ra * 16 + la);
                  #1;
                  e_l = !(la == ra && ord == 1);
                  e_r = !(la == ra && ord != 1);
                  if (la != ra)      tag = "R1 differ";
                  else if (ord == 2) tag = "R3 tie";
                  else               tag = "R2 late loses";
                  if (wc != 0) tag = {tag, " R4 strobes"};
                  chk(tag, {l_busy_o, r_busy_o}, {e_l, e_r});
               end
            end
         end
      end
      idle();
      cyc();

      // hold: right first, left arrives and must stay the loser (R5)
      set_r(1, 0, 5, 0);
      cyc();
      set_l(1, 0, 5, 0);
      #1;
      chk("R2 right earlier", {l_busy_o, r_busy_o}, 2'b01);
      for (int k = 0; k < 3; k++) begin
         cyc();
         #1;
         chk("R5 loser held", {l_busy_o, r_busy_o}, 2'b01);
      end
      cyc();
      set_r(0, 0, 5, 0);
      #1;
      chk("R1 collision ends", {l_busy_o, r_busy_o}, 2'b11);
      idle();
      cyc();

      // master: losing right write suppressed (R6)
      set_l(1, 1, 2, 8'h11);
      cyc();
      set_l(1, 0, 2, 0);
      set_r(1, 1, 2, 8'h22);
      #1;
      chk("R6 right loses", r_busy_o, 0);
      cyc();
      read_l(2, v);
      chk("R6 right write blocked", v, 8'h11);

      // master: losing left write suppressed (R6)
      set_r(1, 1, 3, 8'h66);
      cyc();
      set_r(1, 0, 3, 0);
      set_l(1, 1, 3, 8'h77);
      #1;
      chk("R6 left loses", l_busy_o, 0);
      cyc();
      read_r(3, v);
      chk("R6 left write blocked", v, 8'h66);

      // winner writes while loser reads the same word (R9, R6)
      idle();
      set_l(1, 1, 6, 8'h44);
      cyc();
      set_l(1, 1, 6, 8'h55);
      set_r(1, 0, 6, 0);
      #1;
      chk("R9 reader is loser", r_busy_o, 0);
      cyc();
      chk("R9 loser read old word", r_rdata, 8'h44);
      read_r(6, v);
      chk("R6 winner write lands", v, 8'h55);

      // read data holds while idle (R10)
      idle();
      cyc();
      cyc();
      chk("R10 rdata holds", r_rdata, 8'h55);

      // master ignores busy inputs (R8)
      l_busy_i = 0;
      r_busy_i = 0;
      set_l(1, 1, 1, 8'h5A);
      #1;
      chk("R8 busy out idle", {l_busy_o, r_busy_o}, 2'b11);
      cyc();
      read_l(1, v);
      chk("R8 write not inhibited", v, 8'h5A);
      l_busy_i = 1;
      r_busy_i = 1;

      // slave mode (R7, R11)
      master_mode = 0;
      set_l(1, 1, 7, 8'hA1);
      set_r(1, 1, 7, 8'hB2);
      #1;
      chk("R7 slave busy out high", {l_busy_o, r_busy_o}, 2'b11);
      cyc();
      read_l(7, v);
      chk("R11 left data kept", v, 8'hA1);
      l_busy_i = 0;
      set_l(1, 1, 7, 8'hC3);
      cyc();
      l_busy_i = 1;
      read_r(7, v);
      chk("R7 left inhibited", v, 8'hA1);
      r_busy_i = 0;
      set_r(1, 1, 7, 8'hD4);
      cyc();
      r_busy_i = 1;
      read_l(7, v);
      chk("R7 right inhibited", v, 8'hA1);
      set_r(1, 1, 7, 8'hD4);
      cyc();
      read_l(7, v);
      chk("R7 right normal write", v, 8'hD4);
      held = v;
      read_r(7, v);
      chk("R10 right read", v, held);

      idle();
      cyc();
      finish_run();
   end
endmodule